// File: doc/BRIEF.md
# Burst / Back-Porch Timing Gate

This block turns a composite sync stream into a gate that marks the back porch of each line. Its inputs are a composite sync signal that is active low and already synchronised to the block clock, and a flag that is high while the vertical interval is in progress. Its output is an active-low gate. A downstream clamp or colour-burst sampler uses this gate to decide when to take its sample. The block produces only the timing window. It does no analog sampling, clamping or burst processing.

The gate opens on the rising edge of sync, which is where the sync tip ends. It stays open for a fixed number of clock cycles, set by a parameter. The integrator derives that count from the same scan-rate figure that sets its other video timers, so the window keeps its place in the line at any line rate.

A sync-low run only counts once it has lasted long enough. Outside the vertical interval, the run must reach a horizontal minimum. Inside the vertical interval, equalising and broad pulses appear, and the rising edge at each serration is accepted once the run reaches a shorter vertical minimum. If a qualified edge arrives while the window is already open, the window is restarted from that edge.

Top module: `bp_gate_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first qualified edge, `bp_gate_n` is 1 (inactive).
- R2: A qualified rising edge of `csync_n` is a clock edge that samples `csync_n` = 1 when the previous sample was 0. On such an edge, `bp_gate_n` is 0 from that clock edge onward for exactly `GATE_CYCLES` cycles, then returns to 1.
- R3: With `vert_i` = 0 on the rising-edge sample, the edge qualifies only if `csync_n` was sampled 0 on at least `HSYNC_MIN` consecutive clock edges just before it. Shorter low runs leave `bp_gate_n` at 1.
- R4: With `vert_i` = 1 on the rising-edge sample, the threshold is `VSYNC_MIN` low samples instead of `HSYNC_MIN`, so shorter serration and equalising pulses launch the gate.
- R5: A qualified edge that arrives while the gate is active restarts the window. `bp_gate_n` then stays 0 without a break and ends `GATE_CYCLES` cycles after the latest edge.
- R6: The falling edge of `csync_n` (the sync leading edge) neither opens the gate nor closes an open gate.
- R7: A low run of any length, far longer than either threshold, still qualifies the edge that ends it. The run counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Synchronised composite sync, active low |
| vert_i | input | 1 | High during the vertical interval |
| bp_gate_n | output | 1 | Back-porch gate, active low |

## Verification
The bench builds the block with `GATE_CYCLES` = 6, `HSYNC_MIN` = 4 and `VSYNC_MIN` = 2. With these values every low-run length from 1 to 10 can be swept in both vertical modes, so both qualification boundaries are hit exactly from below and from above. Each gate window is short enough to count in full. A retrigger can also be placed on the last cycle of an open window. A 40-cycle low run checks that the run counter saturates correctly when the run is much longer than either threshold.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef enum logic {
        GP_IDLE = 1'b0,
        GP_OPEN = 1'b1
    } gate_phase_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bpg_edge_qual.sv
module bpg_edge_qual #(
    parameter int unsigned HSYNC_MIN = 120,
    parameter int unsigned VSYNC_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic vert_i,
    output logic trig_o
);
    import bpg_pkg::*;

    localparam int unsigned CAP = max2(HSYNC_MIN, VSYNC_MIN);
    localparam int unsigned RW  = $clog2(CAP + 1);
    localparam logic [RW-1:0] RUN_CAP = RW'(CAP);
    localparam logic [RW-1:0] THR_H   = RW'(HSYNC_MIN);
    localparam logic [RW-1:0] THR_V   = RW'(VSYNC_MIN);

    typedef struct packed {
        logic          prev;
        logic [RW-1:0] run;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic [RW-1:0] thr;

    always_comb begin
        st_d      = st_q;
        st_d.prev = csync_n;
        if (!csync_n) begin
            if (st_q.run != RUN_CAP) begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
        thr    = vert_i ? THR_V : THR_H;
        trig_o = csync_n && !st_q.prev && (st_q.run >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: run counter saturates, never exceeds its cap
    a_r7_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_CAP);

    // R6: a trigger never comes from a sampled-low sync input
    a_r6_trig_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> csync_n);

endmodule

// File: rtl/bpg_width_timer.sv
module bpg_width_timer #(
    parameter int unsigned GATE_CYCLES = 210
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic gate_n_o
);
    import bpg_pkg::*;

    localparam int unsigned CW = $clog2(GATE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(GATE_CYCLES);

    typedef struct packed {
        gate_phase_e   phase;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.phase = GP_OPEN;
            st_d.cnt   = LOAD;
        end else if (st_q.phase == GP_OPEN) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.phase = GP_IDLE;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        gate_n_o = (st_q.phase == GP_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= GP_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an open window always holds a count inside 1..GATE_CYCLES
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == GP_OPEN) |-> (st_q.cnt != '0 && st_q.cnt <= LOAD));

    // R1: idle phase keeps a cleared counter
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == GP_IDLE) |-> (st_q.cnt == '0));

endmodule

// File: rtl/bp_gate_gen.sv
module bp_gate_gen #(
    parameter int unsigned GATE_CYCLES = 210,
    parameter int unsigned HSYNC_MIN   = 120,
    parameter int unsigned VSYNC_MIN   = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic vert_i,
    output logic bp_gate_n
);

    logic trig;

    bpg_edge_qual #(
        .HSYNC_MIN (HSYNC_MIN),
        .VSYNC_MIN (VSYNC_MIN)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .csync_n (csync_n),
        .vert_i  (vert_i),
        .trig_o  (trig)
    );

    bpg_width_timer #(
        .GATE_CYCLES (GATE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .gate_n_o (bp_gate_n)
    );

    // R2: a qualified edge opens the gate on the next cycle
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !bp_gate_n);

    // R2: the gate only opens in response to a trigger
    a_r2_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_gate_n) |-> $past(trig));

    // R6: sync leading edge / low level never opens an idle gate
    a_r6_low_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!csync_n && bp_gate_n) |=> bp_gate_n);

    // R5: a trigger while open keeps the gate open
    a_r5_retrigger_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !bp_gate_n) |=> !bp_gate_n);

endmodule

// File: tb/bp_gate_gen_tb_top.sv
module bp_gate_gen_tb_top;

    localparam int W  = 6;
    localparam int HM = 4;
    localparam int VM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic vert_i = 1'b0;
    logic bp_gate_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bp_gate_gen #(
        .GATE_CYCLES (W),
        .HSYNC_MIN   (HM),
        .VSYNC_MIN   (VM)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csync_n   (csync_n),
        .vert_i    (vert_i),
        .bp_gate_n (bp_gate_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a low run of L cycles, then high for W+4 cycles; count gate-low samples.
    task automatic pulse(input int L, input bit v, output int low_during,
                         output int low_after, output bit first_low);
        low_during = 0;
        low_after  = 0;
        first_low  = 1'b0;
        vert_i  = v;
        csync_n = 1'b0;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            if (!bp_gate_n) low_during++;
        end
        csync_n = 1'b1;
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            if (i == 0) first_low = !bp_gate_n;
            if (!bp_gate_n) low_after++;
        end
    endtask

    initial begin
        int ld, la, hi_seen;
        bit fl, q;
        string tag;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(bp_gate_n == 1'b1, "R1", int'(bp_gate_n), 1);
        rst_n = 1'b1;
        hi_seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bp_gate_n) hi_seen++;
        end
        check(hi_seen == 8, "R1", hi_seen, 8);

        // R2: nominal horizontal pulse
        pulse(5, 1'b0, ld, la, fl);
        check(fl == 1'b1, "R2", int'(fl), 1);
        check(la == W, "R2", la, W);

        // R3 / R4: sweep low-run length in both modes
        for (int v = 0; v < 2; v++) begin
            for (int L = 1; L <= 10; L++) begin
                q   = (L >= ((v != 0) ? VM : HM));
                tag = (v != 0) ? "R4" : "R3";
                pulse(L, v[0], ld, la, fl);
                check(la == (q ? W : 0), tag, la, q ? W : 0);
                check(fl == q, tag, int'(fl), int'(q));
                check(ld == 0, "R6", ld, 0);
            end
        end

        // R5 / R6: retrigger while open
        vert_i  = 1'b0;
        csync_n = 1'b0;
        repeat (5) @(negedge clk);
        csync_n = 1'b1;
        hi_seen = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (bp_gate_n) hi_seen++;
        end
        csync_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bp_gate_n) hi_seen++;
        end
        check(hi_seen == 0, "R6", hi_seen, 0);
        csync_n = 1'b1;
        la = 0;
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            if (!bp_gate_n) la++;
        end
        check(la == W, "R5", la, W);

        // R7: very long low run in both modes
        pulse(40, 1'b0, ld, la, fl);
        check(la == W, "R7", la, W);
        check(ld == 0, "R7", ld, 0);
        pulse(40, 1'b1, ld, la, fl);
        check(la == W, "R7", la, W);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule